// File: doc/BRIEF.md
# Bounded-Depth Chain Redirect Engine

This engine sits between a host that reads and writes logical cells and a physical store of wear-limited entries. Each logical cell lives at the end of a short chain of entries, and the chain starts at the entry whose intermediate address equals the logical index. Every entry has four fields: a lifetime write tally, a per-placement write tally, a link (either absent or an intermediate address) and a data value. Every address the engine produces is an intermediate address. A combinational translator outside the engine turns it into the physical address used on the memory port. Because links hold intermediate addresses, remapping the translator never breaks a chain.

A read walks the chain and returns the value at its end. A write walks the chain and, in the normal case, rewrites the end entry. If the end entry has used up its quota, the engine asks an external allocator for a spare entry. It then hangs that spare under the deepest ancestor that still has link budget, which grows a depth-first traversal of a tree with branching `THRESH_D` and height `DEPTH_H`. Any entries left below that ancestor are released. If no ancestor qualifies, the write is refused with an exhaustion flag. A walk that finds a link at the maximum depth stops and raises a corruption flag.

Top module: `chain_redirect_engine`

## Requirements
- R1: After reset, busy, done, allocReq and memWe are all low.
- R2: A read starts at intermediate address cmdIndex and follows links until it reaches an entry whose linked bit is 0. It returns that entry's value on rdData (0 for an untouched cell) and performs no memory write. For a chain end at depth k, done is high at the (k+2)th cycle after the accepting edge.
- R3: Entry word layout, most significant first: gCnt[8], lCnt[8], linked[1], next[6], value[8]. memAddr always equals xlatPhys, the translation of xlatInter. A stored next field is an intermediate address, so chains still resolve after the translation is changed and the entries are moved to match.
- R4: A write that needs no redirect performs exactly one memory write. That write puts the chain end at gCnt+1, lCnt+1, unlinked, holding the new value. For an end at depth k, done follows k+3 cycles after acceptance.
- R5: A write redirects exactly when the chain end sits at depth k<DEPTH_H with lCnt equal to THRESH_D, or at depth DEPTH_H with lCnt equal to 2*THRESH_D.
- R6: On a redirect, allocReq stays high until allocGrant. The granted entry allocIdx is then written with gCnt+1, lCnt 1, unlinked, holding the new value.
- R7: The parent of a redirect is the deepest visited entry that lies above depth DEPTH_H and has lCnt below 2*THRESH_D. The parent is rewritten last, with gCnt+1, lCnt+1, linked to allocIdx, and value 0.
- R8: Every entry on the old chain below the parent is written with gCnt+1, lCnt 0, unlinked, and value 0. The number of memory writes in a redirect is 2 plus the number of such entries.
- R9: If a redirect is needed and no parent qualifies, errExhaust is set at done. No memory write is made and no allocator request is raised.
- R10: A linked entry found at depth DEPTH_H sets errCorrupt at done, after at most DEPTH_H+1 reads, with no memory write.
- R11: done is a one-cycle pulse. busy stays high from the accepting edge through done, and cmdValid is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command request, accepted when not busy |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdIndex | input | 6 | Logical index, which is also the chain head intermediate address |
| cmdData | input | 8 | Write value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Value read from the chain end |
| errExhaust | output | 1 | Write refused because the tree is full |
| errCorrupt | output | 1 | Walk stopped at the depth bound |
| xlatInter | output | 6 | Intermediate address sent to the translator |
| xlatPhys | input | 6 | Translated physical address |
| memAddr | output | 6 | Physical entry address |
| memWe | output | 1 | Entry write strobe |
| memWdata | output | 31 | Entry write word |
| memRdata | input | 31 | Entry read word, combinational from memAddr |
| allocReq | output | 1 | Spare entry request |
| allocGrant | input | 1 | Allocator grant |
| allocIdx | input | 6 | Granted spare intermediate address |

## Verification
The bench writes one hot cell until its tree is exhausted and inspects every entry involved along the way. Three cases matter most. When a shallow ancestor is chosen as parent, two entries must be released; a design that skipped this would leave stale tallies. A parent with no remaining link budget must be passed over; choosing it would break the depth-first order. The final write must be refused without touching memory; a design that got this wrong would overwrite data or call the allocator. A planted over-long chain checks that the walk stops at the depth bound instead of running on. A translator change with the entries moved to match checks that links hold intermediate rather than physical addresses. A stray command during a busy operation must leave no trace.

// File: rtl/chain_redir_pkg.sv
package chain_redir_pkg;
  parameter int unsigned IDX_W  = 6;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned CNT_W  = 8;

  typedef struct packed {
    logic [CNT_W-1:0]  gCnt;
    logic [CNT_W-1:0]  lCnt;
    logic              linked;
    logic [IDX_W-1:0]  next;
    logic [DATA_W-1:0] value;
  } entry_t;

  localparam int unsigned ENTRY_W = $bits(entry_t);

  typedef enum logic [1:0] {SEL_CUR, SEL_NEW, SEL_FREE, SEL_PARENT} addr_sel_e;
  typedef enum logic [1:0] {WK_TAIL, WK_NEW, WK_FREE, WK_PARENT} wr_kind_e;

  typedef struct packed {
    logic      start;
    logic      walkStep;
    logic      grantLoad;
    logic      freeStep;
    addr_sel_e addrSel;
    wr_kind_e  wrKind;
    logic      memWe;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WALK, ST_WR_TAIL, ST_ALLOC, ST_ALLOC_WR, ST_FREE, ST_PARENT, ST_DONE
  } state_e;
endpackage

// File: rtl/chain_redir_dpath.sv
module chain_redir_dpath
  import chain_redir_pkg::*;
#(
  parameter int unsigned DEPTH_H  = 2,
  parameter int unsigned THRESH_D = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [IDX_W-1:0]   cmdIndex,
  input  logic [DATA_W-1:0]  cmdData,
  input  logic [IDX_W-1:0]   allocIdx,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic [IDX_W-1:0]   xlatInter,
  output logic [ENTRY_W-1:0] memWdata,
  output logic [DATA_W-1:0]  rdData,
  output logic               linkSeen,
  output logic               atBottom,
  output logic               needRedirect,
  output logic               parentAny,
  output logic               hasSubpath,
  output logic               freeLast
);
  localparam int unsigned DEPTH_W = (DEPTH_H < 1) ? 1 : $clog2(DEPTH_H + 1);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = DEPTH_W'(DEPTH_H);
  localparam logic [CNT_W-1:0] QUOTA_LO = CNT_W'(THRESH_D);
  localparam logic [CNT_W-1:0] QUOTA_HI = CNT_W'(2 * THRESH_D);

  entry_t rd, wr;
  assign rd = entry_t'(memRdata);

  logic [IDX_W-1:0]   curAddr, parentAddr, newAddr;
  logic [DEPTH_W-1:0] curDepth, tailDepth, parentDepth, freeDepth;
  logic               parentValid;
  logic [DATA_W-1:0]  dataReg, rdReg;
  logic [IDX_W-1:0]   pathAddr [DEPTH_H+1];
  logic               candidate;

  // an entry above the bottom with link budget left may adopt a new child
  assign candidate    = (curDepth < DEPTH_MAX) && (rd.lCnt < QUOTA_HI);
  assign parentAny    = parentValid || candidate;
  assign linkSeen     = rd.linked;
  assign atBottom     = (curDepth == DEPTH_MAX);
  assign needRedirect = ((curDepth < DEPTH_MAX) && (rd.lCnt == QUOTA_LO)) ||
                        ((curDepth == DEPTH_MAX) && (rd.lCnt == QUOTA_HI));
  assign hasSubpath   = (parentDepth != tailDepth);
  assign freeLast     = (freeDepth == tailDepth);
  assign rdData       = rdReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr     <= '0;
      curDepth    <= '0;
      tailDepth   <= '0;
      parentAddr  <= '0;
      parentDepth <= '0;
      parentValid <= 1'b0;
      newAddr     <= '0;
      freeDepth   <= '0;
      dataReg     <= '0;
      rdReg       <= '0;
    end else begin
      if (stb.start) begin
        curAddr     <= cmdIndex;
        curDepth    <= '0;
        parentValid <= 1'b0;
        dataReg     <= cmdData;
      end
      if (stb.walkStep) begin
        tailDepth <= curDepth;
        if (candidate) begin
          parentAddr  <= curAddr;
          parentDepth <= curDepth;
          parentValid <= 1'b1;
        end
        if (rd.linked) begin
          curAddr  <= rd.next;
          curDepth <= curDepth + 1'b1;
        end else begin
          rdReg <= rd.value;
        end
      end
      if (stb.grantLoad) begin
        newAddr   <= allocIdx;
        freeDepth <= parentDepth + 1'b1;
      end
      if (stb.freeStep) freeDepth <= freeDepth + 1'b1;
    end
  end

  // one address slot per depth level, filled as the walk passes it
  for (genvar j = 0; j <= DEPTH_H; j++) begin : g_path
    always_ff @(posedge clk) begin
      if (rst) pathAddr[j] <= '0;
      else if (stb.walkStep && (curDepth == DEPTH_W'(j))) pathAddr[j] <= curAddr;
    end
  end

  always_comb begin
    case (stb.addrSel)
      SEL_NEW:    xlatInter = newAddr;
      SEL_FREE:   xlatInter = pathAddr[freeDepth];
      SEL_PARENT: xlatInter = parentAddr;
      default:    xlatInter = curAddr;
    endcase
  end

  always_comb begin
    wr        = '0;
    wr.gCnt   = rd.gCnt + 1'b1;
    case (stb.wrKind)
      WK_TAIL: begin
        wr.lCnt  = rd.lCnt + 1'b1;
        wr.value = dataReg;
      end
      WK_NEW: begin
        wr.lCnt  = CNT_W'(1);
        wr.value = dataReg;
      end
      WK_PARENT: begin
        wr.lCnt   = rd.lCnt + 1'b1;
        wr.linked = 1'b1;
        wr.next   = newAddr;
      end
      default: wr.lCnt = '0;
    endcase
  end
  assign memWdata = wr;

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (rst)
    curDepth <= DEPTH_MAX);
  a_r8_free_range: assert property (@(posedge clk) disable iff (rst)
    (stb.memWe && stb.wrKind == WK_FREE) |-> (freeDepth > parentDepth && freeDepth <= tailDepth));
  a_r7_parent_above_bottom: assert property (@(posedge clk) disable iff (rst)
    (stb.memWe && stb.wrKind == WK_PARENT) |-> (parentValid && parentDepth < DEPTH_MAX));
endmodule

// File: rtl/chain_redir_ctrl.sv
module chain_redir_ctrl
  import chain_redir_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmdValid,
  input  logic    cmdWrite,
  input  logic    allocGrant,
  input  logic    linkSeen,
  input  logic    atBottom,
  input  logic    needRedirect,
  input  logic    parentAny,
  input  logic    hasSubpath,
  input  logic    freeLast,
  output strobe_t stb,
  output logic    busy,
  output logic    done,
  output logic    allocReq,
  output logic    errExhaust,
  output logic    errCorrupt
);
  state_e state, nxt;
  logic   opWrite, setCorrupt, setExhaust;

  always_comb begin
    nxt        = state;
    stb        = '0;
    setCorrupt = 1'b0;
    setExhaust = 1'b0;
    case (state)
      ST_IDLE: if (cmdValid) begin
        stb.start = 1'b1;
        nxt       = ST_WALK;
      end
      ST_WALK: begin
        stb.addrSel = SEL_CUR;
        if (linkSeen) begin
          if (atBottom) begin
            setCorrupt = 1'b1;
            nxt        = ST_DONE;
          end else begin
            stb.walkStep = 1'b1;
          end
        end else begin
          stb.walkStep = 1'b1;
          if (!opWrite)          nxt = ST_DONE;
          else if (!needRedirect) nxt = ST_WR_TAIL;
          else if (!parentAny) begin
            setExhaust = 1'b1;
            nxt        = ST_DONE;
          end else               nxt = ST_ALLOC;
        end
      end
      ST_WR_TAIL: begin
        stb.addrSel = SEL_CUR;
        stb.wrKind  = WK_TAIL;
        stb.memWe   = 1'b1;
        nxt         = ST_DONE;
      end
      ST_ALLOC: if (allocGrant) begin
        stb.grantLoad = 1'b1;
        nxt           = ST_ALLOC_WR;
      end
      ST_ALLOC_WR: begin
        stb.addrSel = SEL_NEW;
        stb.wrKind  = WK_NEW;
        stb.memWe   = 1'b1;
        nxt         = hasSubpath ? ST_FREE : ST_PARENT;
      end
      ST_FREE: begin
        stb.addrSel = SEL_FREE;
        stb.wrKind  = WK_FREE;
        stb.memWe   = 1'b1;
        if (freeLast) nxt = ST_PARENT;
        else          stb.freeStep = 1'b1;
      end
      ST_PARENT: begin
        stb.addrSel = SEL_PARENT;
        stb.wrKind  = WK_PARENT;
        stb.memWe   = 1'b1;
        nxt         = ST_DONE;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      opWrite    <= 1'b0;
      errExhaust <= 1'b0;
      errCorrupt <= 1'b0;
    end else begin
      state <= nxt;
      if (stb.start) begin
        opWrite    <= cmdWrite;
        errExhaust <= 1'b0;
        errCorrupt <= 1'b0;
      end
      if (setExhaust) errExhaust <= 1'b1;
      if (setCorrupt) errCorrupt <= 1'b1;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign allocReq = (state == ST_ALLOC);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_done_releases: assert property (@(posedge clk) disable iff (rst) done |=> !busy);
  a_r6_alloc_hold: assert property (@(posedge clk) disable iff (rst)
    (allocReq && !allocGrant) |=> allocReq);
  a_r2_read_no_write: assert property (@(posedge clk) disable iff (rst)
    (busy && !opWrite && !stb.start) |-> !stb.memWe);
  a_r9_exhaust_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && errExhaust) |-> ($past(state) == ST_WALK));
endmodule

// File: rtl/chain_redirect_engine.sv
module chain_redirect_engine
  import chain_redir_pkg::*;
#(
  parameter int unsigned DEPTH_H  = 2,
  parameter int unsigned THRESH_D = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmdValid,
  input  logic               cmdWrite,
  input  logic [IDX_W-1:0]   cmdIndex,
  input  logic [DATA_W-1:0]  cmdData,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdData,
  output logic               errExhaust,
  output logic               errCorrupt,
  output logic [IDX_W-1:0]   xlatInter,
  input  logic [IDX_W-1:0]   xlatPhys,
  output logic [IDX_W-1:0]   memAddr,
  output logic               memWe,
  output logic [ENTRY_W-1:0] memWdata,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic               allocReq,
  input  logic               allocGrant,
  input  logic [IDX_W-1:0]   allocIdx
);
  strobe_t stb;
  logic linkSeen, atBottom, needRedirect, parentAny, hasSubpath, freeLast;

  chain_redir_ctrl u_ctrl (
    .clk, .rst, .cmdValid, .cmdWrite, .allocGrant,
    .linkSeen, .atBottom, .needRedirect, .parentAny, .hasSubpath, .freeLast,
    .stb, .busy, .done, .allocReq, .errExhaust, .errCorrupt
  );

  chain_redir_dpath #(.DEPTH_H(DEPTH_H), .THRESH_D(THRESH_D)) u_dpath (
    .clk, .rst, .stb, .cmdIndex, .cmdData, .allocIdx, .memRdata,
    .xlatInter, .memWdata, .rdData,
    .linkSeen, .atBottom, .needRedirect, .parentAny, .hasSubpath, .freeLast
  );

  assign memAddr = xlatPhys;
  assign memWe   = stb.memWe;
endmodule

// File: tb/chain_redirect_engine_tb.sv
`timescale 1ns/1ps
module chain_redirect_engine_tb_top;
  import chain_redir_pkg::*;

  logic clk = 1'b0, rst = 1'b1;
  logic cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [5:0] cmdIndex = '0;
  logic [7:0] cmdData = '0;
  logic busy, done, errExhaust, errCorrupt, memWe, allocReq, allocGrant;
  logic [7:0] rdData;
  logic [5:0] xlatInter, xlatPhys, memAddr, allocIdx;
  logic [30:0] memWdata, memRdata;

  logic [30:0] mem [64];
  logic [5:0] key = 6'h15;
  logic [5:0] spareNext = 6'd40;
  int reqAge = 0, grantCount = 0, writeCount = 0, cyc = 0;
  logic pokeEn = 1'b0;
  logic [5:0] pokeAddr = '0;
  logic [30:0] pokeData = '0;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  chain_redirect_engine dut_i (
    .clk, .rst, .cmdValid, .cmdWrite, .cmdIndex, .cmdData, .busy, .done, .rdData,
    .errExhaust, .errCorrupt, .xlatInter, .xlatPhys, .memAddr, .memWe, .memWdata,
    .memRdata, .allocReq, .allocGrant, .allocIdx
  );

  assign xlatPhys   = xlatInter ^ key;
  assign memRdata   = mem[memAddr];
  assign allocGrant = allocReq && (reqAge >= 2);
  assign allocIdx   = spareNext;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      reqAge <= 0;
    end else begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        writeCount <= writeCount + 1;
      end else if (pokeEn) mem[pokeAddr] <= pokeData;
      if (allocReq && !allocGrant) reqAge <= reqAge + 1;
      else reqAge <= 0;
      if (allocGrant) begin
        spareNext  <= spareNext + 6'd1;
        grantCount <= grantCount + 1;
      end
    end
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [30:0] mkE(int g, int l, int lk, int nx, int v);
    return {8'(g), 8'(l), 1'(lk), 6'(nx), 8'(v)};
  endfunction

  function automatic logic [5:0] ph(int a);
    return 6'(a) ^ key;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkE(input string req, input int a, input logic [30:0] exp);
    chk(mem[ph(a)] == exp, req, $sformatf("entry %0d", a), 64'(mem[ph(a)]), 64'(exp));
  endtask

  task automatic poke(input logic [5:0] pa, input logic [30:0] pd);
    @(negedge clk); pokeEn = 1'b1; pokeAddr = pa; pokeData = pd;
    @(negedge clk); pokeEn = 1'b0;
  endtask

  task automatic runCmd(input bit wr, input int idx, input int dat, input bit stray,
                        output int lat, output int nWr, output logic [7:0] rdv,
                        output bit ex, output bit co);
    int w0;
    @(negedge clk);
    w0 = writeCount;
    cmdValid = 1'b1; cmdWrite = wr; cmdIndex = 6'(idx); cmdData = 8'(dat);
    @(negedge clk);
    cmdValid = 1'b0; lat = 1;
    while (!done && lat < 60) begin
      if (stray && lat == 1) begin
        cmdValid = 1'b1; cmdWrite = 1'b0; cmdIndex = 6'd3;
      end else cmdValid = 1'b0;
      @(negedge clk); lat++;
    end
    cmdValid = 1'b0;
    chk(done, "R11", "done within limit", 64'(lat), 64'd59);
    rdv = rdData; ex = errExhaust; co = errCorrupt; nWr = writeCount - w0;
  endtask

  task automatic testReset();
    chk(!busy && !done && !allocReq && !memWe, "R1", "idle after reset",
        {busy, done, allocReq, memWe}, 4'b0);
  endtask

  task automatic testEmptyRead();
    int lat, nWr; logic [7:0] v; bit ex, co;
    runCmd(0, 9, 0, 0, lat, nWr, v, ex, co);
    chk(v == 8'd0, "R2", "empty cell value", v, 0);
    chk(lat == 2 && nWr == 0, "R2", "empty read latency/writes", {lat[15:0], nWr[15:0]}, {16'd2, 16'd0});
  endtask

  task automatic testBusyIgnore();
    int lat, nWr; logic [7:0] v; bit ex, co; int extra = 0;
    runCmd(1, 7, 8'h5C, 1, lat, nWr, v, ex, co);
    chk(lat == 3 && nWr == 1, "R4", "plain write latency/writes", {lat[15:0], nWr[15:0]}, {16'd3, 16'd1});
    chkE("R4", 7, mkE(1, 1, 0, 0, 8'h5C));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy || done) extra++;
    end
    chk(extra == 0, "R11", "stray command ignored while busy", extra, 0);
  endtask

  function automatic int expWrites(int n);
    if (n == 3 || n == 5 || n == 15) return 2;
    if (n == 9 || n == 19) return 3;
    if (n == 13) return 4;
    return 1;
  endfunction

  task automatic testHotCell();
    int lat, nWr, g0; logic [7:0] v; bit ex, co;
    for (int n = 1; n <= 22; n++) begin
      runCmd(1, 3, 16 + n, 0, lat, nWr, v, ex, co);
      chk(nWr == expWrites(n), "R8", $sformatf("writes on write %0d", n), nWr, expWrites(n));
      chk(!ex && !co, "R5", $sformatf("no error on write %0d", n), {ex, co}, 0);
      if (n == 1) begin chk(lat == 3, "R4", "depth0 latency", lat, 3); chkE("R4", 3, mkE(1, 1, 0, 0, 17)); end
      if (n == 4) chk(lat == 4, "R4", "depth1 latency", lat, 4);
      if (n == 8) chk(lat == 5, "R4", "depth2 latency", lat, 5);
      if (n == 3) begin
        chkE("R6", 40, mkE(1, 1, 0, 0, 19));
        chkE("R7", 3, mkE(3, 3, 1, 40, 0));
      end
      if (n == 5) begin
        chkE("R6", 41, mkE(1, 1, 0, 0, 21));
        chkE("R7", 40, mkE(3, 3, 1, 41, 0));
      end
      if (n == 9) begin
        chkE("R6", 42, mkE(1, 1, 0, 0, 25));
        chkE("R8", 41, mkE(5, 0, 0, 0, 0));
        chkE("R7", 40, mkE(4, 4, 1, 42, 0));
      end
      if (n == 13) begin
        chkE("R6", 43, mkE(1, 1, 0, 0, 29));
        chkE("R8", 40, mkE(5, 0, 0, 0, 0));
        chkE("R8", 42, mkE(5, 0, 0, 0, 0));
        chkE("R7", 3, mkE(4, 4, 1, 43, 0));
      end
      if (n == 19) begin
        chkE("R6", 45, mkE(1, 1, 0, 0, 35));
        chkE("R8", 44, mkE(5, 0, 0, 0, 0));
        chkE("R7", 43, mkE(4, 4, 1, 45, 0));
      end
      if (n == 22) chkE("R5", 45, mkE(4, 4, 0, 0, 38));
      runCmd(0, 3, 0, 0, lat, nWr, v, ex, co);
      chk(v == 8'(16 + n), "R2", $sformatf("read back after write %0d", n), v, 16 + n);
    end
    chk(grantCount == 6, "R6", "allocator grants", grantCount, 6);
    g0 = grantCount;
    runCmd(1, 3, 8'hEE, 0, lat, nWr, v, ex, co);
    chk(ex && !co, "R9", "exhaust flag", {ex, co}, 2'b10);
    chk(nWr == 0 && grantCount == g0 && lat == 4, "R9", "exhaust quiet",
        {nWr[15:0], lat[15:0]}, {16'd0, 16'd4});
    runCmd(0, 3, 0, 0, lat, nWr, v, ex, co);
    chk(v == 8'd38 && !ex, "R9", "value kept after refusal", v, 38);
  endtask

  task automatic testCorrupt();
    int lat, nWr; logic [7:0] v; bit ex, co;
    poke(ph(5), mkE(0, 0, 1, 50, 0));
    poke(ph(50), mkE(0, 0, 1, 51, 0));
    poke(ph(51), mkE(0, 0, 1, 52, 8'h77));
    runCmd(0, 5, 0, 0, lat, nWr, v, ex, co);
    chk(co && !ex, "R10", "corrupt flag", {co, ex}, 2'b10);
    chk(lat == 4 && nWr == 0, "R10", "bounded walk", {lat[15:0], nWr[15:0]}, {16'd4, 16'd0});
    poke(ph(51), mkE(0, 0, 0, 0, 8'h77));
    runCmd(0, 5, 0, 0, lat, nWr, v, ex, co);
    chk(v == 8'h77 && !co && lat == 4, "R2", "full-depth read", {v, 7'd0, co, lat[7:0]}, {8'h77, 8'd0, 8'd4});
  endtask

  task automatic testRekey();
    int lat, nWr; logic [7:0] v; bit ex, co;
    logic [30:0] snap [64];
    logic [5:0] nk = 6'h2A;
    for (int p = 0; p < 64; p++) snap[p] = mem[p];
    for (int p = 0; p < 64; p++) poke(6'(p) ^ key ^ nk, snap[p]);
    key = nk;
    runCmd(0, 3, 0, 0, lat, nWr, v, ex, co);
    chk(v == 8'd38, "R3", "hot cell after rekey", v, 38);
    runCmd(0, 5, 0, 0, lat, nWr, v, ex, co);
    chk(v == 8'h77, "R3", "planted chain after rekey", v, 8'h77);
    runCmd(0, 7, 0, 0, lat, nWr, v, ex, co);
    chk(v == 8'h5C, "R3", "plain cell after rekey", v, 8'h5C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testEmptyRead();
    testBusyIgnore();
    testHotCell();
    testCorrupt();
    testRekey();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule